// File: doc/BRIEF.md
# Autovectored Interrupt Source Encoder

This block collects fourteen interrupt request lines from endpoint FIFO flags and from a waveform engine. It keeps a pending bit and a mask bit for each source, and drives one combined interrupt request towards the CPU. When the CPU takes the interrupt, it pushes its program counter and jumps to code address 0x0053, where a jump instruction is stored. The jump's high target byte comes unchanged from memory at 0x0054.

With autovectoring enabled, the block watches the instruction-fetch bus. When the CPU fetches the low target byte at 0x0055, the block replaces the memory byte with a vector for the highest-priority unmasked pending source. The jump then lands on that source's own entry in a jump table. The entries are four bytes apart, and the table sits in the page named at 0x0054. A fetch takes two cycles. The address is strobed in one cycle, and the memory data arrives, and leaves the block, in the next cycle. The block decides on a substitution in the address cycle.

Top module: `aiv_encoder`

## Requirements
- R1: Priority is fixed by the request bit index, and bit 0 is the highest. The bits are assigned as follows:
  - Bits 0..3 are the programmable-level flags of endpoints 2, 4, 6 and 8.
  - Bits 4..7 are the empty flags of the same endpoints.
  - Bits 8..11 are the full flags.
  - Bit 12 is waveform "operation complete".
  - Bit 13 is the waveform source.
- R2: The vector for request bit k is 0x80 + 4*k. This runs from 0x80 for bit 0 to 0xB4 for bit 13.
- R3: When the enable bit is 0, every fetched byte passes through unchanged, even at 0x0055 with sources pending.
- R4: With the enable bit set, only a fetch of address 0x0055 is substituted. The substituted byte appears on `fetch_data_o` in the cycle after the address strobe. Fetches of 0x0053, 0x0054 and any other address pass `mem_data_i` through.
- R5: A pending bit is set by a 0-to-1 change of its request line. A line that stays high does not set its bit again after the bit has been cleared.
- R6: Writing a 1 to a bit of the clear word clears that pending bit. If a rising edge of the same source arrives in the same cycle, the set wins and the bit stays pending.
- R7: `irq_o` is high exactly when at least one pending bit has its mask bit at 0. It follows a rising edge one cycle later.
- R8: A mask bit of 1 removes its source from `irq_o` and from the priority choice, but the source still becomes pending. Clearing the mask brings the source back.
- R9: The vector is taken from the pending state as it stands in the cycle of the 0x0055 address strobe. A source that becomes pending in that cycle, or later, does not alter the byte already chosen.
- R10: With the enable bit set and no unmasked source pending, a fetch of 0x0055 returns the memory byte unchanged.
- R11: A reset clears all pending bits, all mask bits and the enable bit. Sources become pending again only on new rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 14 | Interrupt request lines, bit index as in R1 |
| clr_we_i | input | 1 | Strobe for the pending-clear word |
| clr_i | input | 14 | Pending-clear word, a 1 clears the bit |
| mask_we_i | input | 1 | Strobe that loads the mask word |
| mask_i | input | 14 | Mask word, a 1 excludes the source |
| en_we_i | input | 1 | Strobe that loads the autovector enable bit |
| en_i | input | 1 | Autovector enable value |
| fetch_valid_i | input | 1 | Instruction-fetch address strobe |
| fetch_addr_i | input | 16 | Instruction-fetch address |
| mem_data_i | input | 8 | Code byte from program memory, one cycle after the strobe |
| irq_o | output | 1 | Combined interrupt request |
| fetch_data_o | output | 8 | Code byte to the CPU, after any substitution |

## Verification
The assertions take for granted that memory data for a strobed fetch arrives in the following cycle, and that request lines are synchronous to `clk`. They also assume the request lines hold their value through reset, so the first cycle after reset has a defined edge reference. The stimulus works within these limits in the following ways:
- It changes every input away from the active clock edge.
- It presents the memory byte exactly one cycle after each address strobe.
- It keeps the request lines low or steady across each reset.
- It pulses request lines for at least one full cycle.

// File: rtl/aiv_pkg.sv
// Package: shared sizes and constants of the autovectored interrupt encoder.
// Assumes a byte-wide code bus and a 16-bit code address space.
package aiv_pkg;
    localparam int unsigned NSRC      = 14;
    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned VEC_STEP  = 4;
    localparam logic [ADDR_W-1:0] SLOT_ADDR = 16'h0055;
    localparam logic [DATA_W-1:0] VEC_BASE  = 8'h80;
endpackage

// File: rtl/aiv_pending.sv
// Module: per-source pending flags with edge detection, the mask word and the enable bit.
// Assumes the request lines are synchronous to clk. The edge reference follows the lines
// during reset, so a line held high through reset does not count as an edge.
module aiv_pending #(
    parameter int unsigned N = aiv_pkg::NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_i,
    input  logic         en_we_i,
    input  logic         en_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] mask_o,
    output logic         en_o
);
    logic [N-1:0] req_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] mask_q;
    logic         en_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr_v;

    // Rising edges of the requests, and the gated clear word.
    always_comb begin
        rise  = req_i & ~req_q;
        clr_v = clr_we_i ? clr_i : '0;
    end

    // Edge reference, pending bits (a set beats a clear), mask and enable registers.
    always_ff @(posedge clk) begin
        req_q <= req_i;
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
            en_q   <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr_v) | rise;
            if (mask_we_i) mask_q <= mask_i;
            if (en_we_i)   en_q   <= en_i;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign en_o   = en_q;
endmodule

// File: rtl/aiv_prio.sv
// Module: fixed-priority selector. The lowest set index wins.
// Purely combinational; assumes at most a few dozen sources.
module aiv_prio #(
    parameter int unsigned N  = aiv_pkg::NSRC,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  active_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    logic [N:0]   none_below;
    logic [N-1:0] grant;

    assign none_below[0] = 1'b1;

    for (genvar k = 0; k < N; k++) begin : g_chain
        assign none_below[k+1] = none_below[k] & ~active_i[k];
        assign grant[k]        = active_i[k] & none_below[k];
    end

    assign any_o = ~none_below[N];

    // One-hot grant to binary index.
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) idx_o = idx_o | IW'(k);
        end
    end
endmodule

// File: rtl/aiv_subst.sv
// Module: decides on substitution in the fetch address cycle and swaps the returned byte.
// Assumes memory data comes back exactly one cycle after the address strobe.
module aiv_subst #(
    parameter int unsigned       ADDR_W   = aiv_pkg::ADDR_W,
    parameter int unsigned       DATA_W   = aiv_pkg::DATA_W,
    parameter int unsigned       IW       = 4,
    parameter logic [ADDR_W-1:0] VEC_ADDR = aiv_pkg::SLOT_ADDR,
    parameter logic [DATA_W-1:0] VEC_BASE = aiv_pkg::VEC_BASE,
    parameter int unsigned       VEC_STEP = aiv_pkg::VEC_STEP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic [DATA_W-1:0] mem_data_i,
    input  logic              en_i,
    input  logic              any_i,
    input  logic [IW-1:0]     idx_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sub_o
);
    logic              hit;
    logic [DATA_W-1:0] vec_w;
    logic              sub_q;
    logic [DATA_W-1:0] vec_q;

    // Slot fetch detection and the vector of the current winner.
    always_comb begin
        hit   = fetch_valid_i && (fetch_addr_i == VEC_ADDR) && en_i && any_i;
        vec_w = VEC_BASE + DATA_W'(idx_i) * DATA_W'(VEC_STEP);
    end

    // Captures the decision and the vector for the data cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= 1'b0;
            vec_q <= '0;
        end else begin
            sub_q <= hit;
            if (hit) vec_q <= vec_w;
        end
    end

    assign data_o = sub_q ? vec_q : mem_data_i;
    assign sub_o  = sub_q;
endmodule

// File: rtl/aiv_encoder.sv
// Module: top of the autovectored interrupt encoder. It ties the pending bank, the
// priority selector and the fetch substitution together.
// Assumes a synchronous program memory with one cycle of read latency.
module aiv_encoder #(
    parameter int unsigned       N_SRC    = aiv_pkg::NSRC,
    parameter int unsigned       ADDR_W   = aiv_pkg::ADDR_W,
    parameter int unsigned       DATA_W   = aiv_pkg::DATA_W,
    parameter logic [ADDR_W-1:0] VEC_ADDR = aiv_pkg::SLOT_ADDR,
    parameter logic [DATA_W-1:0] VEC_BASE = aiv_pkg::VEC_BASE,
    parameter int unsigned       VEC_STEP = aiv_pkg::VEC_STEP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  req_i,
    input  logic              clr_we_i,
    input  logic [N_SRC-1:0]  clr_i,
    input  logic              mask_we_i,
    input  logic [N_SRC-1:0]  mask_i,
    input  logic              en_we_i,
    input  logic              en_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] fetch_data_o
);
    localparam int unsigned IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] pend_w;
    logic [N_SRC-1:0] mask_w;
    logic             en_w;
    logic [N_SRC-1:0] active_w;
    logic             any_w;
    logic [IDX_W-1:0] idx_w;
    logic             sub_w;

    aiv_pending #(.N(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .clr_we_i(clr_we_i), .clr_i(clr_i),
        .mask_we_i(mask_we_i), .mask_i(mask_i),
        .en_we_i(en_we_i), .en_i(en_i),
        .pend_o(pend_w), .mask_o(mask_w), .en_o(en_w)
    );

    // Unmasked pending sources compete for the vector and the request.
    assign active_w = pend_w & ~mask_w;

    aiv_prio #(.N(N_SRC), .IW(IDX_W)) u_prio (
        .active_i(active_w), .any_o(any_w), .idx_o(idx_w)
    );

    aiv_subst #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IW(IDX_W),
        .VEC_ADDR(VEC_ADDR), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_subst (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
        .mem_data_i(mem_data_i), .en_i(en_w), .any_i(any_w), .idx_i(idx_w),
        .data_o(fetch_data_o), .sub_o(sub_w)
    );

    assign irq_o = any_w;
endmodule

// File: rtl/aiv_checker.sv
// Module: assertion checker for aiv_encoder, attached with bind.
// Assumes memory data arrives one cycle after an address strobe.
module aiv_checker #(
    parameter int unsigned       N        = aiv_pkg::NSRC,
    parameter int unsigned       ADDR_W   = aiv_pkg::ADDR_W,
    parameter int unsigned       DATA_W   = aiv_pkg::DATA_W,
    parameter logic [ADDR_W-1:0] VEC_ADDR = aiv_pkg::SLOT_ADDR,
    parameter logic [DATA_W-1:0] VEC_BASE = aiv_pkg::VEC_BASE,
    parameter int unsigned       VEC_STEP = aiv_pkg::VEC_STEP
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      req_i,
    input logic              fetch_valid_i,
    input logic [ADDR_W-1:0] fetch_addr_i,
    input logic [DATA_W-1:0] mem_data_i,
    input logic [DATA_W-1:0] fetch_data_o,
    input logic [N-1:0]      pend,
    input logic [N-1:0]      mask,
    input logic              en,
    input logic              sub
);
    localparam logic [DATA_W-1:0] VEC_LAST = DATA_W'(int'(VEC_BASE) + (N - 1) * VEC_STEP);

    // R2: a substituted byte is one of the table vectors.
    p_vec_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sub |-> (fetch_data_o >= VEC_BASE && fetch_data_o <= VEC_LAST &&
                 ((int'(fetch_data_o) - int'(VEC_BASE)) % VEC_STEP) == 0));

    // R3: a changed byte needs the enable bit in the address cycle.
    p_disabled_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_data_o != mem_data_i) |-> $past(en && fetch_valid_i));

    // R4: substitution only follows a strobe of the slot address.
    p_slot_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sub |-> $past(fetch_valid_i && fetch_addr_i == VEC_ADDR));

    // R10: substitution only when an unmasked source was pending.
    p_none_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sub |-> $past((pend & ~mask) != '0));

    // R11: the cycle after reset shows cleared state.
    p_reset_clear_r11: assert property (@(posedge clk)
        $past(!rst_n) |-> (pend == '0 && mask == '0 && !en && !sub));

    // R5: every rising request line is pending one cycle later.
    for (genvar i = 0; i < N; i++) begin : g_rise
        p_rise_pends_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_i[i]) |=> pend[i]);
    end
endmodule

bind aiv_encoder aiv_checker #(
    .N(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .VEC_ADDR(VEC_ADDR), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
    .mem_data_i(mem_data_i), .fetch_data_o(fetch_data_o),
    .pend(pend_w), .mask(mask_w), .en(en_w), .sub(sub_w)
);

// File: tb/sim_aiv_encoder.sv
// Bench: directed scenarios, plus a behavioural reference model compared on every clock.
module sim_aiv_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] req = '0;
    logic        clr_we = 1'b0;
    logic [13:0] clr = '0;
    logic        mask_we = 1'b0;
    logic [13:0] mask_v = '0;
    logic        en_we = 1'b0;
    logic        en_v = 1'b0;
    logic        fv = 1'b0;
    logic [15:0] fa = '0;
    logic [7:0]  md = 8'h00;
    logic        irq;
    logic [7:0]  fd;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    bit started = 0;

    aiv_encoder u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .clr_we_i(clr_we), .clr_i(clr),
        .mask_we_i(mask_we), .mask_i(mask_v),
        .en_we_i(en_we), .en_i(en_v),
        .fetch_valid_i(fv), .fetch_addr_i(fa), .mem_data_i(md),
        .irq_o(irq), .fetch_data_o(fd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    bit [13:0] m_pend, m_mask, m_prev;
    bit        m_en, m_sub;
    int        m_vec;

    function automatic int lowest(bit [13:0] v);
        for (int k = 0; k < 14; k++) if (v[k]) return k;
        return -1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model update at each edge, then comparison once the outputs have settled.
    always @(posedge clk) begin
        int w;
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_en = 0; m_sub = 0; m_vec = 0;
        end else begin
            w = lowest(m_pend & ~m_mask);
            m_sub = fv && fa == 16'h0055 && m_en && w >= 0;
            if (m_sub) m_vec = 'h80 + 4 * w;
            m_pend = (m_pend & ~(clr_we ? clr : 14'h0)) | (req & ~m_prev);
            if (mask_we) m_mask = mask_v;
            if (en_we) m_en = en_v;
        end
        m_prev = req;
        started = 1;
        #2;
        if (started && !done) begin
            chk("R7 model irq", int'(irq), int'((m_pend & ~m_mask) != 0));
            chk("R4 model data", int'(fd), m_sub ? m_vec : int'(md));
        end
    end

    task automatic pulse(int k);
        @(negedge clk); req[k] = 1'b1;
        @(negedge clk); req[k] = 1'b0;
    endtask

    task automatic wr_clr(bit [13:0] v);
        @(negedge clk); clr_we = 1; clr = v;
        @(negedge clk); clr_we = 0; clr = '0;
    endtask

    task automatic wr_mask(bit [13:0] v);
        @(negedge clk); mask_we = 1; mask_v = v;
        @(negedge clk); mask_we = 0;
    endtask

    task automatic wr_en(bit v);
        @(negedge clk); en_we = 1; en_v = v;
        @(negedge clk); en_we = 0;
    endtask

    task automatic fetch(logic [15:0] a, logic [7:0] m, output logic [7:0] d);
        @(negedge clk); fv = 1; fa = a;
        @(negedge clk); fv = 0; md = m;
        #1 d = fd;
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R11 reset irq", int'(irq), 0);
        fetch(16'h0055, 8'h3C, d); chk("R10 reset no pending", d, 'h3C);

        wr_en(1);
        // R1 and R2 over every source, one at a time.
        for (int k = 0; k < 14; k++) begin
            pulse(k); #1;
            chk("R7 irq after edge", int'(irq), 1);
            fetch(16'h0055, 8'h11, d); chk("R2 vector", d, 'h80 + 4 * k);
            wr_clr(14'(1) << k);
        end

        pulse(4);
        fetch(16'h0053, 8'h02, d); chk("R4 opcode addr", d, 'h02);
        fetch(16'h0054, 8'h12, d); chk("R4 page addr", d, 'h12);
        fetch(16'h0055, 8'h00, d); chk("R4 slot addr", d, 'h90);
        pulse(0);
        fetch(16'h0055, 8'h00, d); chk("R1 bit0 beats bit4", d, 'h80);
        wr_clr(14'h0001);
        fetch(16'h0055, 8'h00, d); chk("R6 cleared bit0", d, 'h90);
        wr_clr(14'h0010); #1;
        chk("R7 irq low", int'(irq), 0);
        fetch(16'h0055, 8'h5A, d); chk("R10 none pending", d, 'h5A);

        // R8 masking.
        pulse(13);
        wr_mask(14'h2000); #1;
        chk("R8 masked irq", int'(irq), 0);
        fetch(16'h0055, 8'h77, d); chk("R8 masked passthrough", d, 'h77);
        pulse(12);
        fetch(16'h0055, 8'h00, d); chk("R8 other source", d, 'hB0);
        wr_clr(14'h1000); #1;
        chk("R8 masked still excluded", int'(irq), 0);
        wr_mask(14'h0000); #1;
        chk("R8 unmask irq", int'(irq), 1);
        fetch(16'h0055, 8'h00, d); chk("R8 unmasked vector", d, 'hB4);
        wr_clr(14'h3FFF);

        // R3 disabled.
        wr_en(0);
        pulse(3); #1;
        chk("R3 irq still", int'(irq), 1);
        fetch(16'h0055, 8'h44, d); chk("R3 passthrough", d, 'h44);
        wr_clr(14'h0008);
        wr_en(1);

        // R5 held level does not re-pend.
        @(negedge clk); req[6] = 1;
        wr_clr(14'h0040);
        repeat (3) @(negedge clk);
        #1 chk("R5 held level", int'(irq), 0);
        @(negedge clk); req[6] = 0;

        // R6 set beats clear in the same cycle.
        @(negedge clk); req[5] = 1; clr_we = 1; clr = 14'h0020;
        @(negedge clk); req[5] = 0; clr_we = 0; clr = '0;
        #1 chk("R6 set wins", int'(irq), 1);
        fetch(16'h0055, 8'h00, d); chk("R6 vector", d, 'h94);
        wr_clr(14'h0020);

        // R9 capture at the address cycle.
        pulse(10);
        @(negedge clk); fv = 1; fa = 16'h0055; req[1] = 1;
        @(negedge clk); fv = 0; req[1] = 0; md = 8'h11;
        #1 chk("R9 captured vector", int'(fd), 'hA8);
        fetch(16'h0055, 8'h00, d); chk("R9 next fetch", d, 'h84);

        // R11 reset mid-run.
        pulse(2);
        wr_mask(14'h0080);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R11 irq cleared", int'(irq), 0);
        fetch(16'h0055, 8'h66, d); chk("R11 enable cleared", d, 'h66);
        pulse(7); #1;
        chk("R11 mask cleared", int'(irq), 1);
        wr_en(1);
        fetch(16'h0055, 8'h00, d); chk("R11 vector after reset", d, 'h9C);

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule